// File: doc/BRIEF.md
# Snoop Write-Back Responder

This block is the bus-side responder of a processor's write-back data cache. An external agent strobes a snoop with a line address and an invalidate flag. The block looks the line up in a small direct-mapped store that keeps a tag, a coherence state (modified, shared or invalid) and the line's data words. The result appears on two hit outputs two clocks after the strobe is sampled.

When the snoop finds a modified line, the block pulls its modified-hit output low. It then drives the line back to memory as a four-beat burst. That burst goes ahead of any processor access that is waiting for the bus. When the burst has finished, the line becomes shared or invalid, depending on the invalidate flag, and the modified-hit output is released.

The same sequencer also issues single, non-cacheable processor accesses and grants a bus hold request. A hold request that arrives during a write-back is not granted until the burst is complete.

Top module: `snoopResponder`

## Requirements
- R1: After reset, hitModN and snoopHitN are 1, addrStrobeN is 1, holdAck is 0 and cpuDone is 0.
- R2: A snoop strobe sampled low at clock edge N on a line held modified drives hitModN and snoopHitN low after edge N+2.
- R3: A snoop that misses, or that hits a shared line, leaves hitModN high and starts no bus cycle. snoopHitN shows after edge N+2 whether a valid line matched. A shared line hit with snoopInv=1 becomes invalid, and a shared line hit with snoopInv=0 stays valid.
- R4: A snoop strobe is ignored while an earlier snoop is still in its two-clock lookup, while hitModN is low, and while a write-back is pending.
- R5: With the sequencer idle, the write-back starts at the edge after hitModN falls. In that cycle only, addrStrobeN is 0, with writeRead=1, cacheableN=0 and busAddr set to the line's byte base address.
- R6: Burst beat k (k = 0..3) presents busAddr = base + 4k and the line's word k on busData. A beat advances only on an edge where burstReadyN or readyN is low. While neither is low, the address and data hold.
- R7: readyN low in place of burstReadyN completes that beat but not the burst. The burst ends when its fourth beat is accepted, or earlier on a beat accepted with lastN and burstReadyN both low.
- R8: hitModN stays low through the edge that accepts the final beat and returns high at the next edge.
- R9: After the write-back, the line is shared when the snoop's snoopInv was 0 and invalid when it was 1. A later snoop reports snoopHitN low or high accordingly.
- R10: A processor access starts from idle with addrStrobeN=0, cacheableN=1, and busAddr, writeRead and busData taken from cpuAddr, cpuWrite and cpuData. It completes on readyN or burstReadyN low, and cpuDone pulses high for one cycle after that edge. A write-back that is pending when the sequencer becomes idle is issued before a pending processor access.
- R11: holdReq has no effect during a write-back. holdAck rises no earlier than two edges after the final beat is accepted and before any pending processor access starts. holdAck falls at the edge after holdReq is sampled low.
- R12: A snoop is looked up while a processor access is in flight. Its write-back waits until that access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snoopStrobeN | input | 1 | Snoop strobe, active low |
| snoopInv | input | 1 | Invalidate flag of the snoop |
| snoopLine | input | ADDR_W-4 | Snooped line address (byte address without offset bits) |
| hitModN | output | 1 | Low while a snooped modified line is being written back |
| snoopHitN | output | 1 | Low when the last snoop matched a valid line |
| instValid | input | 1 | Install a line into the store |
| instLine | input | ADDR_W-4 | Line address to install |
| instDirty | input | 1 | 1 installs as modified, 0 as shared |
| instData | input | 4*DATA_W | Line words, word k in bits k*DATA_W upward |
| cpuReq | input | 1 | Processor access waiting for the bus |
| cpuWrite | input | 1 | Processor access direction, 1 = write |
| cpuAddr | input | ADDR_W | Processor access address |
| cpuData | input | DATA_W | Processor write data |
| cpuDone | output | 1 | One-cycle pulse when a processor access completes |
| holdReq | input | 1 | Bus hold request |
| holdAck | output | 1 | Bus hold granted |
| readyN | input | 1 | Single-transfer ready, active low |
| burstReadyN | input | 1 | Burst ready, active low |
| lastN | input | 1 | Last transfer of a burst, active low |
| addrStrobeN | output | 1 | Address strobe, active low |
| writeRead | output | 1 | 1 = write, 0 = read |
| cacheableN | output | 1 | Low for cacheable (write-back) cycles |
| busAddr | output | ADDR_W | Bus byte address |
| busData | output | DATA_W | Bus write data |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a snoop lookup and a processor access that is still waiting for ready. The bench strobes a modified line while such an access is open and keeps a second processor request pending. It then judges that hitModN falls on time, that the open access finishes, and that the write-back burst wins the next bus slot ahead of the queued request. The second pair is a hold request and a write-back burst. holdReq is raised after the first beat, and the bench requires holdAck to stay low through the final beat. holdAck must then rise before the pending processor access may start.

// File: rtl/snoopPkg.sv
package snoopPkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'd0,
    LINE_SHR = 2'd1,
    LINE_MOD = 2'd2
  } lineState_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_WB    = 3'd2,
    ST_WBEND = 3'd3,
    ST_CPU   = 3'd4
  } busState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic startWb;
    logic startCpu;
    logic advance;
    logic finishWb;
  } ctrlStrobe_t;

endpackage

// File: rtl/snoopCtrl.sv
module snoopCtrl
  import snoopPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        snoopStrobeN,
  input  logic        pipeBusy,
  input  logic        lookupModHit,
  input  logic        lastBeat,
  input  logic        readyN,
  input  logic        burstReadyN,
  input  logic        lastN,
  input  logic        holdReq,
  input  logic        cpuReq,
  output logic        snoopTake,
  output ctrlStrobe_t strb,
  output logic        hitModN,
  output logic        holdAck,
  output logic        cpuDone
);

  busState_e state;
  logic      wbPending;
  logic      xfer;
  logic      wbEnds;

  assign xfer      = !burstReadyN || !readyN;
  assign wbEnds    = xfer && (lastBeat || (!lastN && !burstReadyN));
  assign snoopTake = !snoopStrobeN && hitModN && !wbPending && !pipeBusy;

  always_comb begin
    strb          = '0;
    strb.startWb  = (state == ST_IDLE) && !holdReq && wbPending;
    strb.startCpu = (state == ST_IDLE) && !holdReq && !wbPending && cpuReq;
    strb.advance  = (state == ST_WB) && xfer && !wbEnds;
    strb.finishWb = (state == ST_WBEND);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wbPending <= 1'b0;
      hitModN   <= 1'b1;
      holdAck   <= 1'b0;
      cpuDone   <= 1'b0;
    end else begin
      cpuDone <= (state == ST_CPU) && xfer;
      if (lookupModHit) begin
        wbPending <= 1'b1;
        hitModN   <= 1'b0;
      end else if (strb.finishWb) begin
        wbPending <= 1'b0;
        hitModN   <= 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (holdReq) begin
            state   <= ST_HOLD;
            holdAck <= 1'b1;
          end else if (strb.startWb) begin
            state <= ST_WB;
          end else if (strb.startCpu) begin
            state <= ST_CPU;
          end
        end
        ST_HOLD: begin
          if (!holdReq) begin
            state   <= ST_IDLE;
            holdAck <= 1'b0;
          end
        end
        ST_WB:    if (wbEnds) state <= ST_WBEND;
        ST_WBEND: state <= ST_IDLE;
        ST_CPU:   if (xfer) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R2: a modified hit from the lookup pulls the hit output low next cycle
  a_r2_hit_after_lookup: assert property (@(posedge clk) disable iff (!rstN)
    lookupModHit |=> !hitModN);

  // R11: no hold grant while the burst runs
  a_r11_no_hold_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WB) |-> !holdAck);

  // R8: the hit output is only released out of the closing state
  a_r8_release_after_burst: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hitModN) |-> $past(state == ST_WBEND));

endmodule

// File: rtl/snoopDatapath.sv
module snoopDatapath
  import snoopPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int BEATS  = 4,
  localparam int WOFF_W = $clog2(DATA_W / 8),
  localparam int BEAT_W = $clog2(BEATS),
  localparam int OFF_W  = WOFF_W + BEAT_W,
  localparam int IDX_W  = $clog2(LINES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int TAG_W  = LINE_W - IDX_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strb,
  input  logic                    snoopTake,
  input  logic                    snoopInv,
  input  logic [LINE_W-1:0]       snoopLine,
  input  logic                    instValid,
  input  logic [LINE_W-1:0]       instLine,
  input  logic                    instDirty,
  input  logic [BEATS*DATA_W-1:0] instData,
  input  logic                    cpuWrite,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [DATA_W-1:0]       cpuData,
  output logic                    pipeBusy,
  output logic                    lookupModHit,
  output logic                    lastBeat,
  output logic                    snoopHitN,
  output logic                    addrStrobeN,
  output logic                    writeRead,
  output logic                    cacheableN,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [DATA_W-1:0]       busData
);

  logic [TAG_W-1:0]  tagQ  [LINES];
  lineState_e        stQ   [LINES];
  logic [DATA_W-1:0] dataQ [LINES][BEATS];

  // lookup pipeline: stage A holds the sampled snoop, stage B the result
  logic             aValid, aInv;
  logic [IDX_W-1:0] aIdx;
  logic [TAG_W-1:0] aTag;
  logic             bValid, bInv, bHit, bMod;
  logic [IDX_W-1:0] bIdx;
  logic             aLineHit;

  logic [IDX_W-1:0]  wbIdx;
  logic              wbInv;
  logic [BEAT_W-1:0] beatQ;
  logic [BEAT_W-1:0] beatNext;

  assign aLineHit     = (stQ[aIdx] != LINE_INV) && (tagQ[aIdx] == aTag);
  assign pipeBusy     = aValid || bValid;
  assign lookupModHit = bValid && bMod;
  assign beatNext     = beatQ + 1'b1;
  assign lastBeat     = (beatQ == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aValid <= 1'b0;
      aInv   <= 1'b0;
      aIdx   <= '0;
      aTag   <= '0;
      bValid <= 1'b0;
      bInv   <= 1'b0;
      bHit   <= 1'b0;
      bMod   <= 1'b0;
      bIdx   <= '0;
    end else begin
      aValid <= snoopTake;
      if (snoopTake) begin
        aInv <= snoopInv;
        aIdx <= snoopLine[IDX_W-1:0];
        aTag <= snoopLine[LINE_W-1:IDX_W];
      end
      bValid <= aValid;
      if (aValid) begin
        bInv <= aInv;
        bIdx <= aIdx;
        bHit <= aLineHit;
        bMod <= aLineHit && (stQ[aIdx] == LINE_MOD);
      end
    end
  end

  // tag and state store
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        tagQ[i] <= '0;
        stQ[i]  <= LINE_INV;
      end
      snoopHitN <= 1'b1;
      wbIdx     <= '0;
      wbInv     <= 1'b0;
    end else begin
      if (instValid) begin
        tagQ[instLine[IDX_W-1:0]] <= instLine[LINE_W-1:IDX_W];
        stQ[instLine[IDX_W-1:0]]  <= instDirty ? LINE_MOD : LINE_SHR;
      end
      if (bValid) begin
        snoopHitN <= !bHit;
        if (bHit && !bMod && bInv) stQ[bIdx] <= LINE_INV;
        if (bMod) begin
          wbIdx <= bIdx;
          wbInv <= bInv;
        end
      end
      if (strb.finishWb) stQ[wbIdx] <= wbInv ? LINE_INV : LINE_SHR;
    end
  end

  always_ff @(posedge clk) begin
    if (instValid) begin
      for (int k = 0; k < BEATS; k++)
        dataQ[instLine[IDX_W-1:0]][k] <= instData[k*DATA_W +: DATA_W];
    end
  end

  // bus output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrStrobeN <= 1'b1;
      writeRead   <= 1'b0;
      cacheableN  <= 1'b1;
      busAddr     <= '0;
      busData     <= '0;
      beatQ       <= '0;
    end else begin
      addrStrobeN <= !(strb.startWb || strb.startCpu);
      if (strb.startWb) begin
        beatQ      <= '0;
        writeRead  <= 1'b1;
        cacheableN <= 1'b0;
        busAddr    <= {tagQ[wbIdx], wbIdx, {OFF_W{1'b0}}};
        busData    <= dataQ[wbIdx][0];
      end else if (strb.startCpu) begin
        writeRead  <= cpuWrite;
        cacheableN <= 1'b1;
        busAddr    <= cpuAddr;
        busData    <= cpuData;
      end else if (strb.advance) begin
        beatQ   <= beatNext;
        busAddr <= {tagQ[wbIdx], wbIdx, beatNext, {WOFF_W{1'b0}}};
        busData <= dataQ[wbIdx][beatNext];
      end
    end
  end

  // R5: the address strobe is a single-cycle pulse
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !addrStrobeN |=> addrStrobeN);

  // R4: at most one snoop in the lookup pipeline
  a_r4_one_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({aValid, bValid}));

  // R6: without a start or an accepted beat the bus address and data hold
  a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.startWb || strb.startCpu || strb.advance) |=> ($stable(busAddr) && $stable(busData)));

endmodule

// File: rtl/snoopResponder.sv
module snoopResponder
  import snoopPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int BEATS  = 4,
  localparam int LINE_W = ADDR_W - $clog2(DATA_W / 8) - $clog2(BEATS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    snoopStrobeN,
  input  logic                    snoopInv,
  input  logic [LINE_W-1:0]       snoopLine,
  output logic                    hitModN,
  output logic                    snoopHitN,
  input  logic                    instValid,
  input  logic [LINE_W-1:0]       instLine,
  input  logic                    instDirty,
  input  logic [BEATS*DATA_W-1:0] instData,
  input  logic                    cpuReq,
  input  logic                    cpuWrite,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [DATA_W-1:0]       cpuData,
  output logic                    cpuDone,
  input  logic                    holdReq,
  output logic                    holdAck,
  input  logic                    readyN,
  input  logic                    burstReadyN,
  input  logic                    lastN,
  output logic                    addrStrobeN,
  output logic                    writeRead,
  output logic                    cacheableN,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [DATA_W-1:0]       busData
);

  ctrlStrobe_t strb;
  logic        snoopTake;
  logic        pipeBusy;
  logic        lookupModHit;
  logic        lastBeat;

  snoopCtrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .snoopStrobeN (snoopStrobeN),
    .pipeBusy     (pipeBusy),
    .lookupModHit (lookupModHit),
    .lastBeat     (lastBeat),
    .readyN       (readyN),
    .burstReadyN  (burstReadyN),
    .lastN        (lastN),
    .holdReq      (holdReq),
    .cpuReq       (cpuReq),
    .snoopTake    (snoopTake),
    .strb         (strb),
    .hitModN      (hitModN),
    .holdAck      (holdAck),
    .cpuDone      (cpuDone)
  );

  snoopDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES),
    .BEATS  (BEATS)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .snoopTake    (snoopTake),
    .snoopInv     (snoopInv),
    .snoopLine    (snoopLine),
    .instValid    (instValid),
    .instLine     (instLine),
    .instDirty    (instDirty),
    .instData     (instData),
    .cpuWrite     (cpuWrite),
    .cpuAddr      (cpuAddr),
    .cpuData      (cpuData),
    .pipeBusy     (pipeBusy),
    .lookupModHit (lookupModHit),
    .lastBeat     (lastBeat),
    .snoopHitN    (snoopHitN),
    .addrStrobeN  (addrStrobeN),
    .writeRead    (writeRead),
    .cacheableN   (cacheableN),
    .busAddr      (busAddr),
    .busData      (busData)
  );

endmodule

// File: tb/snoopResponder_tb.sv
`timescale 1ns/1ps
module snoopResponder_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NL = 4;
  localparam int NB = 4;
  localparam int LW = AW - 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, snoopStrobeN, snoopInv, hitModN, snoopHitN;
  logic [LW-1:0] snoopLine, instLine;
  logic instValid, instDirty;
  logic [NB*DW-1:0] instData;
  logic cpuReq, cpuWrite, cpuDone, holdReq, holdAck;
  logic [AW-1:0] cpuAddr, busAddr;
  logic [DW-1:0] cpuData, busData;
  logic readyN, burstReadyN, lastN, addrStrobeN, writeRead, cacheableN;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  snoopResponder #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .BEATS(NB)) dut_i (
    .clk(clk), .rstN(rstN), .snoopStrobeN(snoopStrobeN), .snoopInv(snoopInv),
    .snoopLine(snoopLine), .hitModN(hitModN), .snoopHitN(snoopHitN),
    .instValid(instValid), .instLine(instLine), .instDirty(instDirty), .instData(instData),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuDone(cpuDone), .holdReq(holdReq), .holdAck(holdAck), .readyN(readyN),
    .burstReadyN(burstReadyN), .lastN(lastN), .addrStrobeN(addrStrobeN),
    .writeRead(writeRead), .cacheableN(cacheableN), .busAddr(busAddr), .busData(busData)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] lineOf(int idx, int tag);
    return LW'((tag << 2) | idx);
  endfunction

  function automatic logic [AW-1:0] baseOf(int idx, int tag);
    return AW'(((tag << 2) | idx) << 4);
  endfunction

  function automatic logic [DW-1:0] wordOf(int idx, int tag, int k);
    return DW'((tag << 16) | (idx << 8) | k) ^ 32'h5A00_0000;
  endfunction

  task automatic install(int idx, int tag, bit dirty);
    instLine  = lineOf(idx, tag);
    instDirty = dirty;
    for (int k = 0; k < NB; k++) instData[k*DW +: DW] = wordOf(idx, tag, k);
    instValid = 1'b1;
    tick();
    instValid = 1'b0;
  endtask

  task automatic snoopPulse(int idx, int tag, bit inv);
    snoopLine    = lineOf(idx, tag);
    snoopInv     = inv;
    snoopStrobeN = 1'b0;
    tick();
    snoopStrobeN = 1'b1;
  endtask

  task automatic snoopResult(int idx, int tag, bit inv, bit expMod, bit expHit, string req);
    snoopPulse(idx, tag, inv);
    tick();
    tick();
    check(req, hitModN, !expMod);
    check(req, snoopHitN, !expHit);
  endtask

  // called in the cycle where the burst's first beat is on the bus
  task automatic runBurst(int idx, int tag, logic [3:0] readyMask, int waitBeat, string req);
    for (int k = 0; k < NB; k++) begin
      check(req, busAddr, baseOf(idx, tag) + AW'(4 * k));
      check(req, busData, wordOf(idx, tag, k));
      check(req, writeRead, 1'b1);
      if (k == waitBeat) begin
        tick();
        check(req, busAddr, baseOf(idx, tag) + AW'(4 * k));
        check(req, addrStrobeN, 1'b1);
      end
      if (readyMask[k]) readyN = 1'b0;
      else burstReadyN = 1'b0;
      lastN = !(k == NB - 1 && !readyMask[k]);
      tick();
      readyN = 1'b1;
      burstReadyN = 1'b1;
      lastN = 1'b1;
    end
  endtask

  task automatic closeBurst(string req);
    check(req, hitModN, 1'b0);
    tick();
    check(req, hitModN, 1'b1);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; snoopStrobeN = 1'b1; snoopInv = 1'b0; snoopLine = '0;
    instValid = 1'b0; instLine = '0; instDirty = 1'b0; instData = '0;
    cpuReq = 1'b0; cpuWrite = 1'b0; cpuAddr = '0; cpuData = '0;
    holdReq = 1'b0; readyN = 1'b1; burstReadyN = 1'b1; lastN = 1'b1;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check("R1", hitModN, 1'b1);
    check("R1", snoopHitN, 1'b1);
    check("R1", addrStrobeN, 1'b1);
    check("R1", holdAck, 1'b0);
    check("R1", cpuDone, 1'b0);

    // sweep: every line, both invalidate values, burst-ready and plain-ready beats
    for (int idx = 0; idx < NL; idx++) begin
      for (int inv = 0; inv < 2; inv++) begin
        for (int mode = 0; mode < 2; mode++) begin
          int tag;
          tag = 1 + idx + 4 * inv + 8 * mode;
          install(idx, tag, 1'b1);
          snoopResult(idx, tag, inv[0], 1'b1, 1'b1, "R2");
          tick();
          check("R5", addrStrobeN, 1'b0);
          check("R5", cacheableN, 1'b0);
          check("R5", writeRead, 1'b1);
          check("R5", busAddr, baseOf(idx, tag));
          runBurst(idx, tag, mode ? 4'b1010 : 4'b0000, mode ? 2 : -1, mode ? "R7" : "R6");
          closeBurst("R8");
          snoopResult(idx, tag, 1'b0, 1'b0, !inv[0], "R9");
        end
      end
    end

    // R7 early end on last with burst-ready at beat 1
    install(2, 40, 1'b1);
    snoopResult(2, 40, 1'b0, 1'b1, 1'b1, "R2");
    tick();
    burstReadyN = 1'b0;
    tick();
    check("R7", busAddr, baseOf(2, 40) + AW'(4));
    lastN = 1'b0;
    tick();
    burstReadyN = 1'b1;
    lastN = 1'b1;
    closeBurst("R7");
    snoopResult(2, 40, 1'b0, 1'b0, 1'b1, "R7");

    // R3 misses and shared hits
    install(1, 50, 1'b0);
    snoopResult(1, 51, 1'b0, 1'b0, 1'b0, "R3");
    snoopResult(1, 50, 1'b0, 1'b0, 1'b1, "R3");
    tick();
    check("R3", addrStrobeN, 1'b1);
    snoopResult(1, 50, 1'b1, 1'b0, 1'b1, "R3");
    snoopResult(1, 50, 1'b0, 1'b0, 1'b0, "R3");
    install(2, 60, 1'b1);
    snoopResult(2, 61, 1'b1, 1'b0, 1'b0, "R3");
    tick();
    check("R3", addrStrobeN, 1'b1);

    // R4 strobes during lookup and during hitModN low are ignored
    install(0, 70, 1'b0);
    snoopLine = lineOf(2, 60); snoopInv = 1'b0; snoopStrobeN = 1'b0;
    tick();
    snoopLine = lineOf(0, 70); snoopInv = 1'b1;
    tick();
    snoopStrobeN = 1'b1;
    tick();
    check("R4", hitModN, 1'b0);
    snoopStrobeN = 1'b0;
    tick();
    snoopStrobeN = 1'b1;
    check("R4", addrStrobeN, 1'b0);
    runBurst(2, 60, 4'b0000, -1, "R6");
    closeBurst("R8");
    snoopResult(0, 70, 1'b0, 1'b0, 1'b1, "R4");

    // R10 / R12 snoop during a processor access, write-back before queued access
    install(3, 80, 1'b1);
    cpuAddr = 16'h1234; cpuWrite = 1'b1; cpuData = 32'hCAFE_0001; cpuReq = 1'b1;
    tick();
    check("R10", addrStrobeN, 1'b0);
    check("R10", cacheableN, 1'b1);
    check("R10", busAddr, 16'h1234);
    check("R10", writeRead, 1'b1);
    check("R10", busData, 32'hCAFE_0001);
    cpuAddr = 16'h2222; cpuWrite = 1'b0;
    snoopPulse(3, 80, 1'b1);
    tick();
    tick();
    check("R12", hitModN, 1'b0);
    check("R12", addrStrobeN, 1'b1);
    readyN = 1'b0;
    tick();
    readyN = 1'b1;
    check("R10", cpuDone, 1'b1);
    tick();
    check("R10", cpuDone, 1'b0);
    check("R10", addrStrobeN, 1'b0);
    check("R10", cacheableN, 1'b0);
    check("R10", busAddr, baseOf(3, 80));
    runBurst(3, 80, 4'b0000, -1, "R6");
    closeBurst("R8");
    tick();
    check("R10", addrStrobeN, 1'b0);
    check("R10", busAddr, 16'h2222);
    check("R10", writeRead, 1'b0);
    check("R10", cacheableN, 1'b1);
    burstReadyN = 1'b0;
    tick();
    burstReadyN = 1'b1;
    cpuReq = 1'b0;
    check("R10", cpuDone, 1'b1);
    snoopResult(3, 80, 1'b0, 1'b0, 1'b0, "R9");

    // R11 hold raised during a burst
    install(1, 90, 1'b1);
    snoopResult(1, 90, 1'b0, 1'b1, 1'b1, "R2");
    tick();
    check("R11", addrStrobeN, 1'b0);
    burstReadyN = 1'b0;
    tick();
    burstReadyN = 1'b1;
    holdReq = 1'b1;
    cpuReq = 1'b1; cpuAddr = 16'h3333; cpuWrite = 1'b0;
    for (int k = 1; k < NB; k++) begin
      check("R11", holdAck, 1'b0);
      check("R11", busAddr, baseOf(1, 90) + AW'(4 * k));
      burstReadyN = 1'b0;
      lastN = !(k == NB - 1);
      tick();
      burstReadyN = 1'b1;
      lastN = 1'b1;
    end
    check("R11", holdAck, 1'b0);
    tick();
    check("R11", holdAck, 1'b0);
    check("R8", hitModN, 1'b1);
    tick();
    check("R11", holdAck, 1'b1);
    check("R11", addrStrobeN, 1'b1);
    tick();
    check("R11", holdAck, 1'b1);
    check("R11", addrStrobeN, 1'b1);
    holdReq = 1'b0;
    tick();
    check("R11", holdAck, 1'b0);
    tick();
    check("R10", addrStrobeN, 1'b0);
    check("R10", busAddr, 16'h3333);
    readyN = 1'b0;
    tick();
    readyN = 1'b1;
    cpuReq = 1'b0;
    check("R10", cpuDone, 1'b1);
    tick();

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule